// File: doc/BRIEF.md
# Timer Input Capture Channel Unit

This block watches four external pins and records the value of a free-running timer count when a chosen transition shows up on a pin. Each channel has its own capture register and a sticky event flag. The flags are cleared by software with write-one-to-clear strobes. A single interrupt request combines the flags of the channels whose interrupt enable is set. The timer count, channel mode bits, edge choices, enables and pin direction bits are inputs. The counter, any compare logic and the register bus sit outside this block.

Each pin first passes through a two-stage synchronizer. A counting filter follows, and it accepts a new pin level only after the level has been sampled the same way for a set number of consecutive clocks, so short glitches never reach the edge detector. A detected edge turns into a capture only when the channel is in capture mode and its pin is set as an input.

Top module: `tcap_unit`

## Requirements
- R1: During and after synchronous reset, every capture register reads 0, every flag reads 0 and the interrupt output is 0.
- R2: On a qualifying edge, the channel's capture register takes the count value present at the clock edge where the capture is taken, and the channel flag is set.
- R3: The 2-bit edge select of channel n sits at bits [2n+1:2n] of `edge_sel`: 00 means no edge, 01 means rising, 10 means falling and 11 means both edges.
- R4: A new pin level is accepted only after it has been sampled for FILT_LEN consecutive clocks (3 by default). A pulse of 2 clocks causes no capture, and a pulse of 3 clocks is accepted.
- R5: A capture is taken only when the channel's mode bit `ch_is_out[n]` is 0 and its direction bit `dir_out[n]` is 0. Otherwise the capture register and the flag stay unchanged.
- R6: Pulsing `flag_clr[n]` high for one clock clears flag n at that edge. Flags whose `flag_clr` bit is 0 are not affected.
- R7: When a capture and a clear strike the same flag at the same edge, the flag ends up set.
- R8: `irq` is registered. It equals the OR over channels of (flag AND `irq_en`) one clock after those values, and it is 0 while `irq_en` is all zero.
- R9: If the new pin level is first sampled at rising edge E0, the capture register and flag update at edge E5: two synchronizer stages, three filter samples and one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Free-running timer count |
| pin_in | input | NUM_CH | Asynchronous channel pins |
| ch_is_out | input | NUM_CH | Channel mode: 0 capture, 1 compare (no capture) |
| dir_out | input | NUM_CH | Pin direction: 0 input, 1 output |
| edge_sel | input | 2*NUM_CH | Per-channel edge select |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| flag_clr | input | NUM_CH | Write-one-to-clear strobes for the flags |
| cap_val | output | NUM_CH*CNT_W | Capture registers, channel n at [n*CNT_W +: CNT_W] |
| flags | output | NUM_CH | Sticky capture flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its defaults: four channels, a 16-bit count and a filter length of 3. With a filter length of 3, the two-clock and three-clock pulses fall on either side of the acceptance threshold, so both the rejection and the acceptance of a pulse can be checked. The count value changes part-way through each long pulse, so the value that ends up in a capture register shows which edge was taken. Four channels let one vector table give each edge select code its own pin and confirm that idle channels stay quiet.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic lvl
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl   <= 1'b0;
      run_q <= '0;
    end else if (sync_in == lvl) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      lvl   <= sync_in;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // level may only move once a full run of differing samples was counted
  assert_no_short_change_R4: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |-> ($past(run_q) == LAST));
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             is_out,
  input  logic             dir_out,
  input  logic [1:0]       sel,
  input  logic             clr,
  output logic [CNT_W-1:0] cap_q,
  output logic             flag_q
);
  edge_sel_e sel_e;
  logic      lvl_d;
  logic      rise, fall, hit, ev;

  assign sel_e = edge_sel_e'(sel);
  assign rise  = lvl & ~lvl_d;
  assign fall  = ~lvl & lvl_d;

  always_comb begin
    case (sel_e)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign ev = hit & ~is_out & ~dir_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d  <= 1'b0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      lvl_d  <= lvl;
      if (ev) cap_q <= cnt_val;
      flag_q <= (flag_q & ~clr) | ev;
    end
  end

  assert_cap_value_R2: assert property (@(posedge clk) disable iff (rst)
    (cap_q != $past(cap_q)) |-> (cap_q == $past(cnt_val)));

  assert_cap_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !$past(flag_q)) |-> (!$past(is_out) && !$past(dir_out)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev) |=> !flag_q);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && ev) |=> flag_q);
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit #(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 16,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          cnt_val,
  input  logic [NUM_CH-1:0]         pin_in,
  input  logic [NUM_CH-1:0]         ch_is_out,
  input  logic [NUM_CH-1:0]         dir_out,
  input  logic [2*NUM_CH-1:0]       edge_sel,
  input  logic [NUM_CH-1:0]         irq_en,
  input  logic [NUM_CH-1:0]         flag_clr,
  output logic [NUM_CH*CNT_W-1:0]   cap_val,
  output logic [NUM_CH-1:0]         flags,
  output logic                      irq
);
  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] pin_lvl;

  tcap_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pin_in),
    .d_out (pin_sync)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tcap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .sync_in (pin_sync[n]),
      .lvl     (pin_lvl[n])
    );

    tcap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .lvl     (pin_lvl[n]),
      .cnt_val (cnt_val),
      .is_out  (ch_is_out[n]),
      .dir_out (dir_out[n]),
      .sel     (edge_sel[2*n +: 2]),
      .clr     (flag_clr[n]),
      .cap_q   (cap_val[n*CNT_W +: CNT_W]),
      .flag_q  (flags[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & irq_en);
  end

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(flags) != '0));
endmodule

// File: tb/test_tcap_unit.sv
module test_tcap_unit;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int NV     = 9;
  localparam int VW     = 48;

  // {ch[1:0], sel[1:0], is_out, dir, width[7:0], exp[1:0] (0 none, 1 A, 2 B), A[15:0], B[15:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 2'b01, 1'b0, 1'b0, 8'd4,  2'd1, 16'h1111, 16'h2222},
    {2'd1, 2'b10, 1'b0, 1'b0, 8'd4,  2'd2, 16'h3333, 16'h4444},
    {2'd2, 2'b11, 1'b0, 1'b0, 8'd10, 2'd2, 16'h5555, 16'h6666},
    {2'd3, 2'b00, 1'b0, 1'b0, 8'd10, 2'd0, 16'h7777, 16'h8888},
    {2'd0, 2'b01, 1'b0, 1'b0, 8'd2,  2'd0, 16'h9999, 16'hAAAA},
    {2'd1, 2'b11, 1'b0, 1'b0, 8'd3,  2'd2, 16'hBBBB, 16'hCCCC},
    {2'd2, 2'b01, 1'b1, 1'b0, 8'd6,  2'd0, 16'hDDDD, 16'hEEEE},
    {2'd3, 2'b01, 1'b0, 1'b1, 8'd6,  2'd0, 16'h0F0F, 16'hF0F0},
    {2'd3, 2'b10, 1'b0, 1'b0, 8'd5,  2'd2, 16'h1234, 16'h5678}
  };

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [CNT_W-1:0]        cnt_val = '0;
  logic [NUM_CH-1:0]       pin_in = '0;
  logic [NUM_CH-1:0]       ch_is_out = '0;
  logic [NUM_CH-1:0]       dir_out = '0;
  logic [2*NUM_CH-1:0]     edge_sel = '0;
  logic [NUM_CH-1:0]       irq_en = '0;
  logic [NUM_CH-1:0]       flag_clr = '0;
  logic [NUM_CH*CNT_W-1:0] cap_val;
  logic [NUM_CH-1:0]       flags;
  logic                    irq;

  int checks = 0;
  int failures = 0;
  logic [CNT_W-1:0] exp_cap [NUM_CH] = '{default: '0};

  always #4 clk = ~clk;

  tcap_unit i_tcap_unit (
    .clk, .rst, .cnt_val, .pin_in, .ch_is_out, .dir_out, .edge_sel,
    .irq_en, .flag_clr, .cap_val, .flags, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", 32'(flags), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 caps after reset", 32'(|cap_val), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // vector table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int ch, width, ex, total;
      logic [1:0] sel;
      logic [CNT_W-1:0] a, b;
      ch    = int'(VEC[v][47:46]);
      sel   = VEC[v][45:44];
      width = int'(VEC[v][41:34]);
      ex    = int'(VEC[v][33:32]);
      a     = VEC[v][31:16];
      b     = VEC[v][15:0];
      edge_sel = '0;
      edge_sel[2*ch +: 2] = sel;
      ch_is_out = '0;
      ch_is_out[ch] = VEC[v][43];
      dir_out = '0;
      dir_out[ch] = VEC[v][42];
      clear_all();
      cnt_val = a;
      pin_in[ch] = 1'b1;
      total = ((width > 6) ? width : 6) + 14;
      for (int i = 1; i <= total; i++) begin
        @(negedge clk);
        if (i == width) pin_in[ch] = 1'b0;
        if (i == 6) cnt_val = b;
      end
      if (ex == 1) exp_cap[ch] = a;
      if (ex == 2) exp_cap[ch] = b;
      chk($sformatf("R2 R3 R4 R5 vec%0d flags", v), 32'(flags),
          (ex != 0) ? (32'h1 << ch) : 32'h0);
      chk($sformatf("R2 R3 R4 R5 vec%0d cap", v), 32'(cap_val[ch*CNT_W +: CNT_W]),
          32'(exp_cap[ch]));
    end

    // latency, irq, clear (R9 R8 R6)
    edge_sel = 8'b0000_0001;
    ch_is_out = '0;
    dir_out = '0;
    clear_all();
    cnt_val = 16'hABCD;
    pin_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 no flag before E5", 32'(flags[0]), 32'h0);
    @(negedge clk);
    chk("R9 flag at E5", 32'(flags[0]), 32'h1);
    chk("R9 cap at E5", 32'(cap_val[0 +: CNT_W]), 32'hABCD);
    repeat (2) @(negedge clk);
    chk("R8 irq masked", 32'(irq), 32'h0);
    irq_en = 4'b0001;
    @(negedge clk);
    chk("R8 irq raised", 32'(irq), 32'h1);
    flag_clr = 4'b1110;
    @(negedge clk);
    flag_clr = '0;
    chk("R6 other clear bits ignored", 32'(flags[0]), 32'h1);
    flag_clr = 4'b0001;
    @(negedge clk);
    flag_clr = '0;
    chk("R6 flag cleared", 32'(flags[0]), 32'h0);
    @(negedge clk);
    chk("R8 irq dropped", 32'(irq), 32'h0);
    irq_en = '0;
    pin_in[0] = 1'b0;
    repeat (10) @(negedge clk);

    // set wins over clear (R7)
    cnt_val = 16'h0BEE;
    pin_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    flag_clr = 4'b0001;
    @(negedge clk);
    flag_clr = '0;
    chk("R7 set beats clear", 32'(flags[0]), 32'h1);
    chk("R7 cap taken", 32'(cap_val[0 +: CNT_W]), 32'h0BEE);
    pin_in[0] = 1'b0;
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule